// File: doc/BRIEF.md
# Interlaced Raster Timing and Interrupt Generator

This block sets the timing of a 50 Hz interlaced raster. A horizontal position counter moves forward by 8 on each clock and wraps at a line total set by a parameter. A line counter advances each time the horizontal counter wraps. A field flag flips at the end of every frame. From this position the block derives the horizontal and vertical sync levels, a four-way output stage (sync, blank, colour burst or pixels) and two single-clock interrupt pulses. One pulse is a periodic frame timer. The other marks the end of the visible display, and its line depends on whether text or graphics mode is selected.

On the odd field the vertical sync window moves by half a line, and the frame timer pulse moves to the mid-line position with it. This produces the half-line offset that interlacing needs. Every output is registered together with the position that produced it. A consumer can therefore read `h_pos`, `v_pos` and `field` in the same cycle as the sync, stage and interrupt outputs, and all of them describe the same raster position. All line, frame, sync, burst and interrupt positions are parameters. No pin carries a data stream, so no handshake is needed.

Top module: `vid_raster_timer`

## Requirements
- R1: While `rst_n` is low, `h_pos`, `v_pos`, `field`, `hsync`, `vsync`, `timer_irq` and `dend_irq` are 0 and `stage` is blank (code 1). The first position presented after reset is horizontal 0, line 0, field 0.
- R2: From one cycle to the next, `h_pos` rises by 8. After LINE_TOTAL-8 it returns to 0. `v_pos` changes only when `h_pos` wraps: it goes up by one, and after V_LAST it returns to 0.
- R3: `field` inverts when `v_pos` wraps to 0 and holds its value at every other position.
- R4: `hsync` is high when `h_pos` is at least HSYNC_START and below HSYNC_END.
- R5: On field 0, `vsync` is high from (line VSYNC_START, horizontal 0) up to, but not including, (line VSYNC_END, horizontal H_HALF).
- R6: On field 1, `vsync` is high from (line VSYNC_START, horizontal H_HALF) up to, but not including, (line VSYNC_END+1, horizontal 0).
- R7: `timer_irq` pulses for one cycle at line TIMER_LINE. The position is horizontal 0 on field 0 and horizontal H_HALF on field 1.
- R8: `dend_irq` pulses for one cycle at horizontal HSYNC_START. The line is DEND_TXT_LINE when `text_mode` is 1 and DEND_GFX_LINE when it is 0.
- R9: `stage` encodes sync=0, blank=1, burst=2, pixels=3. It is sync when either sync is high. Otherwise, inside blanking (h ≥ H_ACTIVE or line ≥ V_ACTIVE) it is burst for BURST_START ≤ h < BURST_END and blank at all other blanking positions. Outside blanking it is pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| text_mode | input | 1 | Selects the text-mode display-end line |
| h_pos | output | $clog2(LINE_TOTAL) | Horizontal position of the presented outputs |
| v_pos | output | $clog2(V_LAST+1) | Line of the presented outputs |
| field | output | 1 | Field of the presented outputs (0 even, 1 odd) |
| hsync | output | 1 | Horizontal sync level |
| vsync | output | 1 | Vertical sync level |
| stage | output | 2 | Output stage code |
| timer_irq | output | 1 | Frame timer pulse |
| dend_irq | output | 1 | Display-end pulse |

## Verification
The bench runs four full frames of a small raster, so both fields are covered in both modes. It checks every output against a position model of its own at every cycle. A design that swaps the field rules would start or end vsync half a line early or late, or would put the timer pulse at horizontal 0 on the odd field. A design with an off-by-one in the wrap would skip or repeat the last line, or flip the field at the wrong time. An edge error in the burst or sync windows would misreport the stage at the window boundaries. The `text_mode` input is switched between frames to catch a display-end pulse that lands on the line of the other mode.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
  typedef enum logic [1:0] {
    STG_SYNC  = 2'd0,
    STG_BLANK = 2'd1,
    STG_BURST = 2'd2,
    STG_PIXEL = 2'd3
  } stage_e;
endpackage

// File: rtl/vrt_counters.sv
module vrt_counters #(
  parameter int LINE_TOTAL = 1024,
  parameter int V_LAST     = 311,
  localparam int HW = $clog2(LINE_TOTAL),
  localparam int VW = $clog2(V_LAST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] cur_h,
  output logic [VW-1:0] cur_v,
  output logic          cur_field
);
  localparam logic [HW-1:0] H_STEP = HW'(8);
  localparam logic [HW-1:0] H_END  = HW'(LINE_TOTAL - 8);
  localparam logic [VW-1:0] V_END  = VW'(V_LAST);

  logic line_wrap, frame_wrap;
  assign line_wrap  = (cur_h == H_END);
  assign frame_wrap = line_wrap && (cur_v == V_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_h     <= '0;
      cur_v     <= '0;
      cur_field <= 1'b0;
    end else begin
      cur_h <= line_wrap ? '0 : cur_h + H_STEP;
      if (frame_wrap) begin
        cur_v     <= '0;
        cur_field <= ~cur_field;
      end else if (line_wrap) begin
        cur_v <= cur_v + VW'(1);
      end
    end
  end
endmodule

// File: rtl/vrt_sync.sv
module vrt_sync #(
  parameter int LINE_TOTAL  = 1024,
  parameter int V_LAST      = 311,
  parameter int H_HALF      = 512,
  parameter int HSYNC_START = 768,
  parameter int HSYNC_END   = 832,
  parameter int VSYNC_START = 274,
  parameter int VSYNC_END   = 276,
  localparam int HW = $clog2(LINE_TOTAL),
  localparam int VW = $clog2(V_LAST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cur_h,
  input  logic [VW-1:0] cur_v,
  input  logic          cur_field,
  output logic          hs_nx,
  output logic          vs_nx,
  output logic          hs_q,
  output logic          vs_q
);
  localparam logic [HW-1:0] HS_ON  = HW'(HSYNC_START);
  localparam logic [HW-1:0] HS_OFF = HW'(HSYNC_END);
  localparam logic [HW-1:0] HMID   = HW'(H_HALF);
  localparam logic [VW-1:0] VS_ON  = VW'(VSYNC_START);
  localparam logic [VW-1:0] VS_OFF = VW'(VSYNC_END);
  localparam logic [VW-1:0] VS_OFF_ODD = VW'(VSYNC_END + 1);

  logic at_zero, at_mid;
  assign at_zero = (cur_h == '0);
  assign at_mid  = (cur_h == HMID);

  always_comb begin
    hs_nx = hs_q;
    if (cur_h == HS_ON)       hs_nx = 1'b1;
    else if (cur_h == HS_OFF) hs_nx = 1'b0;

    vs_nx = vs_q;
    if (!cur_field) begin
      if (at_zero && cur_v == VS_ON)      vs_nx = 1'b1;
      else if (at_mid && cur_v == VS_OFF) vs_nx = 1'b0;
    end else begin
      if (at_mid && cur_v == VS_ON)            vs_nx = 1'b1;
      else if (at_zero && cur_v == VS_OFF_ODD) vs_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hs_nx;
      vs_q <= vs_nx;
    end
  end
endmodule

// File: rtl/vrt_events.sv
module vrt_events
  import vrt_pkg::*;
#(
  parameter int LINE_TOTAL    = 1024,
  parameter int V_LAST        = 311,
  parameter int H_HALF        = 512,
  parameter int HSYNC_START   = 768,
  parameter int H_ACTIVE      = 640,
  parameter int V_ACTIVE      = 256,
  parameter int BURST_START   = 856,
  parameter int BURST_END     = 896,
  parameter int TIMER_LINE    = 100,
  parameter int DEND_GFX_LINE = 256,
  parameter int DEND_TXT_LINE = 250,
  localparam int HW = $clog2(LINE_TOTAL),
  localparam int VW = $clog2(V_LAST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cur_h,
  input  logic [VW-1:0] cur_v,
  input  logic          cur_field,
  input  logic          text_mode,
  input  logic          hs_nx,
  input  logic          vs_nx,
  output stage_e        stage_q,
  output logic          timer_q,
  output logic          dend_q
);
  localparam logic [HW-1:0] HMID  = HW'(H_HALF);
  localparam logic [HW-1:0] HS_ON = HW'(HSYNC_START);
  localparam logic [HW-1:0] HACT  = HW'(H_ACTIVE);
  localparam logic [HW-1:0] BST_A = HW'(BURST_START);
  localparam logic [HW-1:0] BST_B = HW'(BURST_END);
  localparam logic [VW-1:0] VACT  = VW'(V_ACTIVE);
  localparam logic [VW-1:0] TLINE = VW'(TIMER_LINE);
  localparam logic [VW-1:0] DGFX  = VW'(DEND_GFX_LINE);
  localparam logic [VW-1:0] DTXT  = VW'(DEND_TXT_LINE);

  stage_e stage_nx;
  logic   timer_nx, dend_nx, in_blank;

  always_comb begin
    in_blank = (cur_h >= HACT) || (cur_v >= VACT);
    if (hs_nx || vs_nx)                         stage_nx = STG_SYNC;
    else if (!in_blank)                         stage_nx = STG_PIXEL;
    else if (cur_h >= BST_A && cur_h < BST_B)   stage_nx = STG_BURST;
    else                                        stage_nx = STG_BLANK;

    timer_nx = (cur_v == TLINE) && (cur_field ? (cur_h == HMID) : (cur_h == '0));
    dend_nx  = (cur_h == HS_ON) && (cur_v == (text_mode ? DTXT : DGFX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_BLANK;
      timer_q <= 1'b0;
      dend_q  <= 1'b0;
    end else begin
      stage_q <= stage_nx;
      timer_q <= timer_nx;
      dend_q  <= dend_nx;
    end
  end
endmodule

// File: rtl/vid_raster_timer.sv
module vid_raster_timer
  import vrt_pkg::*;
#(
  parameter int LINE_TOTAL    = 1024,
  parameter int V_LAST        = 311,
  parameter int H_HALF        = 512,
  parameter int HSYNC_START   = 768,
  parameter int HSYNC_END     = 832,
  parameter int H_ACTIVE      = 640,
  parameter int V_ACTIVE      = 256,
  parameter int BURST_START   = 856,
  parameter int BURST_END     = 896,
  parameter int VSYNC_START   = 274,
  parameter int VSYNC_END     = 276,
  parameter int TIMER_LINE    = 100,
  parameter int DEND_GFX_LINE = 256,
  parameter int DEND_TXT_LINE = 250,
  localparam int HW = $clog2(LINE_TOTAL),
  localparam int VW = $clog2(V_LAST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          text_mode,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          field,
  output logic          hsync,
  output logic          vsync,
  output logic [1:0]    stage,
  output logic          timer_irq,
  output logic          dend_irq
);
  logic [HW-1:0] cur_h;
  logic [VW-1:0] cur_v;
  logic          cur_field, hs_nx, vs_nx;
  stage_e        stage_q;

  vrt_counters #(.LINE_TOTAL(LINE_TOTAL), .V_LAST(V_LAST)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .cur_h(cur_h), .cur_v(cur_v), .cur_field(cur_field)
  );

  vrt_sync #(
    .LINE_TOTAL(LINE_TOTAL), .V_LAST(V_LAST), .H_HALF(H_HALF),
    .HSYNC_START(HSYNC_START), .HSYNC_END(HSYNC_END),
    .VSYNC_START(VSYNC_START), .VSYNC_END(VSYNC_END)
  ) sync_i (
    .clk(clk), .rst_n(rst_n),
    .cur_h(cur_h), .cur_v(cur_v), .cur_field(cur_field),
    .hs_nx(hs_nx), .vs_nx(vs_nx), .hs_q(hsync), .vs_q(vsync)
  );

  vrt_events #(
    .LINE_TOTAL(LINE_TOTAL), .V_LAST(V_LAST), .H_HALF(H_HALF),
    .HSYNC_START(HSYNC_START), .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
    .BURST_START(BURST_START), .BURST_END(BURST_END),
    .TIMER_LINE(TIMER_LINE), .DEND_GFX_LINE(DEND_GFX_LINE),
    .DEND_TXT_LINE(DEND_TXT_LINE)
  ) evt_i (
    .clk(clk), .rst_n(rst_n),
    .cur_h(cur_h), .cur_v(cur_v), .cur_field(cur_field),
    .text_mode(text_mode), .hs_nx(hs_nx), .vs_nx(vs_nx),
    .stage_q(stage_q), .timer_q(timer_irq), .dend_q(dend_irq)
  );

  assign stage = stage_q;

  // Position stage: holds the position the registered outputs describe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_pos <= '0;
      v_pos <= '0;
      field <= 1'b0;
    end else begin
      h_pos <= cur_h;
      v_pos <= cur_v;
      field <= cur_field;
    end
  end
endmodule

// File: rtl/vrt_checker.sv
module vrt_checker
  import vrt_pkg::*;
#(
  parameter int LINE_TOTAL  = 1024,
  parameter int V_LAST      = 311,
  parameter int HSYNC_START = 768,
  parameter int HSYNC_END   = 832,
  localparam int HW = $clog2(LINE_TOTAL),
  localparam int VW = $clog2(V_LAST + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] h_pos,
  input logic [VW-1:0] v_pos,
  input logic          field,
  input logic          hsync,
  input logic          vsync,
  input logic [1:0]    stage,
  input logic          timer_irq,
  input logic          dend_irq
);
  localparam logic [HW-1:0] STEP = HW'(8);

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && h_pos != '0) |-> (HW'(h_pos - $past(h_pos)) == STEP)); // R2
  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && h_pos != '0) |-> $stable(v_pos)); // R2
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (h_pos != '0 || v_pos != '0)) |-> $stable(field)); // R3
  AST_HSYNC_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> (h_pos >= HW'(HSYNC_START) && h_pos < HW'(HSYNC_END))); // R4
  AST_TIMER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |=> !timer_irq); // R7
  AST_DEND_POS: assert property (@(posedge clk) disable iff (!rst_n)
    dend_irq |-> (h_pos == HW'(HSYNC_START))); // R8
  AST_SYNC_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync) |-> (stage == STG_SYNC)); // R9
endmodule

bind vid_raster_timer vrt_checker #(
  .LINE_TOTAL(LINE_TOTAL), .V_LAST(V_LAST),
  .HSYNC_START(HSYNC_START), .HSYNC_END(HSYNC_END)
) chk_i (
  .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos), .field(field),
  .hsync(hsync), .vsync(vsync), .stage(stage),
  .timer_irq(timer_irq), .dend_irq(dend_irq)
);

// File: tb/vid_raster_timer_tb.sv
`timescale 1ns/1ps
module vid_raster_timer_tb_top;
  localparam int LT = 128, VL = 19, HH = 64, HS0 = 96, HS1 = 112;
  localparam int HA = 80, VA = 14, B0 = 112, B1 = 120;
  localparam int VS0 = 16, VS1 = 17, TL = 15, DG = 13, DT = 12;
  localparam int HW = $clog2(LT), VW = $clog2(VL + 1);

  logic clk = 1'b0, rst_n = 1'b0, text_mode = 1'b0;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic field, hsync, vsync, timer_irq, dend_irq;
  logic [1:0] stage;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vid_raster_timer #(
    .LINE_TOTAL(LT), .V_LAST(VL), .H_HALF(HH), .HSYNC_START(HS0), .HSYNC_END(HS1),
    .H_ACTIVE(HA), .V_ACTIVE(VA), .BURST_START(B0), .BURST_END(B1),
    .VSYNC_START(VS0), .VSYNC_END(VS1), .TIMER_LINE(TL),
    .DEND_GFX_LINE(DG), .DEND_TXT_LINE(DT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .text_mode(text_mode), .h_pos(h_pos), .v_pos(v_pos),
    .field(field), .hsync(hsync), .vsync(vsync), .stage(stage),
    .timer_irq(timer_irq), .dend_irq(dend_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lin(input int v, input int h);
    return v * LT + h;
  endfunction

  initial begin
    int eh = 0, ev = 0, ef = 0, tm_used;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 h_pos", int'(h_pos), 0);
    chk("R1 v_pos", int'(v_pos), 0);
    chk("R1 field", int'(field), 0);
    chk("R1 syncs", int'({hsync, vsync}), 0);
    chk("R1 irqs", int'({timer_irq, dend_irq}), 0);
    chk("R1 stage", int'(stage), 1);
    tm_used = 0;
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4 * LT / 8 * (VL + 1); cyc++) begin
      int p, exp_hs, exp_vs, exp_st, exp_tm, exp_de;
      @(negedge clk);
      p = lin(ev, eh);
      exp_hs = (eh >= HS0 && eh < HS1) ? 1 : 0;
      if (ef == 0) exp_vs = (p >= lin(VS0, 0) && p < lin(VS1, HH)) ? 1 : 0;
      else         exp_vs = (p >= lin(VS0, HH) && p < lin(VS1 + 1, 0)) ? 1 : 0;
      if (exp_hs == 1 || exp_vs == 1) exp_st = 0;
      else if (eh < HA && ev < VA)    exp_st = 3;
      else if (eh >= B0 && eh < B1)   exp_st = 2;
      else                            exp_st = 1;
      exp_tm = (ev == TL && eh == (ef == 1 ? HH : 0)) ? 1 : 0;
      exp_de = (eh == HS0 && ev == (tm_used == 1 ? DT : DG)) ? 1 : 0;
      chk("R2 h_pos", int'(h_pos), eh);
      chk("R2 v_pos", int'(v_pos), ev);
      chk("R3 field", int'(field), ef);
      chk("R4 hsync", int'(hsync), exp_hs);
      chk(ef == 1 ? "R6 vsync odd" : "R5 vsync even", int'(vsync), exp_vs);
      chk("R7 timer_irq", int'(timer_irq), exp_tm);
      chk("R8 dend_irq", int'(dend_irq), exp_de);
      chk("R9 stage", int'(stage), exp_st);
      eh += 8;
      if (eh == LT) begin
        eh = 0;
        if (ev == VL) begin ev = 0; ef ^= 1; end
        else ev++;
      end
      // text mode changes every two frames, applied from the next edge
      text_mode = ((cyc + 1) / (LT / 8 * (VL + 1))) >= 2;
      tm_used = int'(text_mode);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule